// File: doc/BRIEF.md
# External Data Memory Cycle Sequencer

This block runs one access at a time to an external byte-wide data memory over a multiplexed bus. The low address byte and the data share one set of wires, and the high address byte has pins of its own. A request gives a 16-bit address, a direction flag and a write byte. The sequencer then drives an address-latch strobe, places the strobes for the access and returns a one-clock completion pulse. On a read, the byte it captured from the bus comes back with that pulse. Every interval is a whole number of core clock periods, set by parameters.

The bus is split into an output value, an output enable and an input value, so that a pad ring or a tri-state wrapper can join them. An access lasts fourteen periods with the default parameters. A new request can be taken in the period after the completion pulse.

Top module: `xmem_cycle_seq`

## Requirements
- R1: While reset is applied and after it is released with no request, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `ad_out`=0, `addr_hi`=0, `busy`=0 and `done`=0.
- R2: A request taken at a clock edge raises `ale` in the next period and keeps it high for exactly 2 periods. `ad_out` carries address bits [7:0] with `ad_oe`=1 while `ale` is high and for 1 more period after it falls.
- R3: On a read (`req_write`=0), `rd_n` falls exactly 3 periods after `ale` falls and stays low for exactly 6 periods. `wr_n` stays 1.
- R4: On a write (`req_write`=1), `wr_n` falls exactly 3 periods after `ale` falls and stays low for exactly 6 periods. `rd_n` stays 1.
- R5: `rd_n` and `wr_n` are never both 0.
- R6: On a write, `ad_out` carries the write byte with `ad_oe`=1 from the period after the address hold through the period after `wr_n` rises. That gives 2 periods before the strobe falls and 1 period after it rises. `ad_oe` is 0 after that.
- R7: On a read, `ad_oe` is 0 from the period after the address hold until the access ends. This includes the 2 periods after `rd_n` rises.
- R8: On a read, `rdata` takes the `ad_in` value present at the clock edge that ends the last period of `rd_n` low. It is shown no later than the `done` period and holds until the next read completes. A write leaves `rdata` unchanged.
- R9: `addr_hi` carries address bits [15:8] from the first `ale` period through the last period before `done`, and is 0 otherwise.
- R10: `busy` is 1 for all 14 periods of an access. `done` is 1 only in the last of them, which comes 2 periods after the strobe rises, with both strobes high and `ad_oe`=0.
- R11: A request is taken only while `busy`=0. A request raised or changed during an access has no effect on that access's outputs, and no access follows it unless it is still present once `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-period completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Multiplexed address/data bus, output value |
| ad_oe | output | 1 | Output enable for the multiplexed bus |
| ad_in | input | 8 | Multiplexed address/data bus, input value |

## Verification
The bench walks a single one across all sixteen address bits, and adds the all-zero and all-one addresses, in both directions. Each access has its own data byte, so a byte lane mixed up between the high and low address or the data, or a stuck bit, shows up at a known period. On reads, the external byte is correct only in the one period that ends at the capture edge and is inverted in every other period, so a capture one period early or late reads back the wrong value. Some accesses keep a conflicting request asserted all the way through, which separates a design that takes requests only when idle from one that restarts or lets the new address or direction leak onto the bus.

// File: rtl/xmem_seq_pkg.sv
package xmem_seq_pkg;

  // Access phases, in the order the sequencer walks them
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ALE   = 3'd1,
    PH_AHOLD = 3'd2,
    PH_SETUP = 3'd3,
    PH_STRB  = 3'd4,
    PH_TAIL  = 3'd5,
    PH_DONE  = 3'd6
  } xphase_e;

  function automatic xphase_e phase_after(xphase_e p);
    case (p)
      PH_ALE:   return PH_AHOLD;
      PH_AHOLD: return PH_SETUP;
      PH_SETUP: return PH_STRB;
      PH_STRB:  return PH_TAIL;
      PH_TAIL:  return PH_DONE;
      default:  return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/xmem_phase_timer.sv
module xmem_phase_timer
  import xmem_seq_pkg::*;
#(
  parameter int ALE_CYC   = 2,
  parameter int AHOLD_CYC = 1,
  parameter int STB_DLY   = 3,
  parameter int STB_CYC   = 6,
  parameter int TAIL_CYC  = 2,
  parameter int CW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output xphase_e       phase_q,
  output logic [CW-1:0] cnt_q,
  output xphase_e       phase_d,
  output logic [CW-1:0] cnt_d
);

  localparam int SETUP_CYC = STB_DLY - AHOLD_CYC;

  function automatic logic [CW-1:0] last_cnt(xphase_e p);
    case (p)
      PH_ALE:   return CW'(ALE_CYC - 1);
      PH_AHOLD: return CW'(AHOLD_CYC - 1);
      PH_SETUP: return CW'(SETUP_CYC - 1);
      PH_STRB:  return CW'(STB_CYC - 1);
      PH_TAIL:  return CW'(TAIL_CYC - 1);
      default:  return '0;
    endcase
  endfunction

  logic adv_en;

  // next-state
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (phase_q == PH_IDLE) begin
      if (start) begin
        phase_d = PH_ALE;
        cnt_d   = '0;
      end
    end else if (cnt_q == last_cnt(phase_q)) begin
      phase_d = phase_after(phase_q);
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign adv_en = (phase_q != PH_IDLE) || start;

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (adv_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/xmem_bus_drive.sv
module xmem_bus_drive
  import xmem_seq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int STB_CYC  = 6,
  parameter int WHLD_CYC = 1,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  xphase_e       phase_q,
  input  logic [CW-1:0] cnt_q,
  input  xphase_e       phase_d,
  input  logic [CW-1:0] cnt_d,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          done,
  output logic [DW-1:0] rdata
);

  localparam int HW = AW - DW;

  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          cur_wr;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;

  logic          ale_d, rd_n_d, wr_n_d, oe_d, done_d;
  logic [HW-1:0] hi_d;
  logic [DW-1:0] out_d;
  logic          cap_en;

  // request latch, loaded only when an access starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign cur_wr    = start ? req_write : wr_q;
  assign cur_addr  = start ? req_addr  : addr_q;
  assign cur_wdata = start ? req_wdata : wdata_q;

  // pin values for the coming period, decoded from the next phase
  always_comb begin
    ale_d  = 1'b0;
    rd_n_d = 1'b1;
    wr_n_d = 1'b1;
    oe_d   = 1'b0;
    out_d  = '0;
    hi_d   = '0;
    done_d = 1'b0;
    case (phase_d)
      PH_ALE: begin
        ale_d = 1'b1;
        oe_d  = 1'b1;
        out_d = cur_addr[DW-1:0];
        hi_d  = cur_addr[AW-1:DW];
      end
      PH_AHOLD: begin
        oe_d  = 1'b1;
        out_d = cur_addr[DW-1:0];
        hi_d  = cur_addr[AW-1:DW];
      end
      PH_SETUP: begin
        oe_d  = cur_wr;
        out_d = cur_wr ? cur_wdata : '0;
        hi_d  = cur_addr[AW-1:DW];
      end
      PH_STRB: begin
        rd_n_d = cur_wr;
        wr_n_d = !cur_wr;
        oe_d   = cur_wr;
        out_d  = cur_wr ? cur_wdata : '0;
        hi_d   = cur_addr[AW-1:DW];
      end
      PH_TAIL: begin
        oe_d  = cur_wr && (cnt_d < CW'(WHLD_CYC));
        out_d = oe_d ? cur_wdata : '0;
        hi_d  = cur_addr[AW-1:DW];
      end
      PH_DONE: done_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      ad_oe   <= 1'b0;
      ad_out  <= '0;
      addr_hi <= '0;
      done    <= 1'b0;
    end else begin
      ale     <= ale_d;
      rd_n    <= rd_n_d;
      wr_n    <= wr_n_d;
      ad_oe   <= oe_d;
      ad_out  <= out_d;
      addr_hi <= hi_d;
      done    <= done_d;
    end
  end

  // read capture at the edge that closes the last strobe-low period
  assign cap_en = (phase_q == PH_STRB) && (cnt_q == CW'(STB_CYC - 1)) && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap_en) begin
      rdata <= ad_in;
    end
  end

endmodule

// File: rtl/xmem_cycle_seq.sv
module xmem_cycle_seq
  import xmem_seq_pkg::*;
#(
  parameter int ALE_CYC   = 2,
  parameter int AHOLD_CYC = 1,
  parameter int STB_DLY   = 3,
  parameter int STB_CYC   = 6,
  parameter int TAIL_CYC  = 2,
  parameter int WHLD_CYC  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdata,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  addr_hi,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  ad_in
);

  localparam int AW    = 16;
  localparam int DW    = 8;
  localparam int SPAN  = ALE_CYC + STB_DLY + STB_CYC + TAIL_CYC + 1;
  localparam int CW    = $clog2(SPAN + 1);

  logic          rst_meta, rst_sync;
  logic          start;
  xphase_e       phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign start = req_valid && (phase_q == PH_IDLE) && rst_sync;
  assign busy  = (phase_q != PH_IDLE);

  xmem_phase_timer #(
    .ALE_CYC  (ALE_CYC),
    .AHOLD_CYC(AHOLD_CYC),
    .STB_DLY  (STB_DLY),
    .STB_CYC  (STB_CYC),
    .TAIL_CYC (TAIL_CYC),
    .CW       (CW)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync),
    .start  (start),
    .phase_q(phase_q),
    .cnt_q  (cnt_q),
    .phase_d(phase_d),
    .cnt_d  (cnt_d)
  );

  xmem_bus_drive #(
    .AW      (AW),
    .DW      (DW),
    .STB_CYC (STB_CYC),
    .WHLD_CYC(WHLD_CYC),
    .CW      (CW)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_sync),
    .start    (start),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .phase_q  (phase_q),
    .cnt_q    (cnt_q),
    .phase_d  (phase_d),
    .cnt_d    (cnt_d),
    .ad_in    (ad_in),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr_hi  (addr_hi),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .done     (done),
    .rdata    (rdata)
  );

endmodule

// File: rtl/xmem_cycle_seq_chk.sv
module xmem_cycle_seq_chk #(
  parameter int ALE_CYC = 2,
  parameter int STB_DLY = 3,
  parameter int STB_CYC = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ad_oe,
  input logic [7:0] ad_out,
  input logic [7:0] addr_hi,
  input logic       done,
  input logic       busy
);

  localparam int KW = $clog2(ALE_CYC + STB_DLY + STB_CYC + 4) + 1;
  localparam logic [KW-1:0] KMAX = '1;

  logic [KW-1:0] ale_len, since_ale, low_len;
  logic          stb_idle;

  assign stb_idle = rd_n && wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_len   <= '0;
      since_ale <= '0;
      low_len   <= '0;
    end else begin
      ale_len   <= ale ? ((ale_len == KMAX) ? ale_len : ale_len + 1'b1) : '0;
      since_ale <= ale ? '0 : ((since_ale == KMAX) ? since_ale : since_ale + 1'b1);
      low_len   <= stb_idle ? '0 : ((low_len == KMAX) ? low_len : low_len + 1'b1);
    end
  end

  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ale_len == KW'(ALE_CYC)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ad_oe && $stable(ad_out)); // R2
  AST_STB_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_idle) |-> since_ale == KW'(STB_DLY)); // R3
  AST_STB_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_idle) |-> low_len == KW'(STB_CYC)); // R4
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n || wr_n); // R5
  AST_WR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> ad_oe && $past(ad_oe) && $stable(ad_out)); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe && $stable(ad_out)); // R6
  AST_RD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> !ad_oe ##1 !ad_oe); // R7
  AST_RD_NOBUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R7
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_idle |-> $stable(addr_hi)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy && stb_idle && !ad_oe && !ale); // R10

endmodule

bind xmem_cycle_seq xmem_cycle_seq_chk #(
  .ALE_CYC(ALE_CYC),
  .STB_DLY(STB_DLY),
  .STB_CYC(STB_CYC)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ale    (ale),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .ad_oe  (ad_oe),
  .ad_out (ad_out),
  .addr_hi(addr_hi),
  .done   (done),
  .busy   (busy)
);

// File: tb/xmem_cycle_seq_test.sv
`timescale 1ns/1ps
module xmem_cycle_seq_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        busy, done, ale, rd_n, wr_n, ad_oe;
  logic [7:0]  rdata, addr_hi, ad_out, ad_in;

  int n_chk;
  int n_bad;
  logic [7:0] exp_rdata;
  bit finished;

  xmem_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // one access; cycle t counts periods after the accepting edge
  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d, input bit jam);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    for (int t = 0; t <= 14; t++) begin
      @(negedge clk);
      if (t == 0) begin
        if (jam) begin
          req_write = !wr;
          req_addr  = ~a;
          req_wdata = ~d;
        end else begin
          req_valid = 1'b0;
        end
      end
      if (t == 13) req_valid = 1'b0;
      chk("R2 ale", ale, t < 2);
      chk("R2/R6/R7 ad_oe", ad_oe, (t < 3) || (wr && t >= 3 && t <= 11));
      chk("R2/R6 ad_out", ad_out, (t < 3) ? a[7:0] : ((wr && t <= 11) ? d : 8'h00));
      chk("R3/R5 rd_n", rd_n, !(!wr && t >= 5 && t <= 10));
      chk("R4/R5 wr_n", wr_n, !(wr && t >= 5 && t <= 10));
      chk("R9 addr_hi", addr_hi, (t <= 12) ? a[15:8] : 8'h00);
      chk("R10 busy", busy, t <= 13);
      chk("R10 done", done, t == 13);
      if (t == 13 && !wr) exp_rdata = d;
      if (t >= 13) chk("R8 rdata", rdata, exp_rdata);
      if (t == 14) chk("R11 no restart", busy, 1'b0);
      // external byte is right only at the capture edge
      ad_in = (t == 10) ? d : ~d;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    finished = 1'b0;
    exp_rdata = 8'h00;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    ad_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 ale in reset", ale, 1'b0);
    chk("R1 rd_n in reset", rd_n, 1'b1);
    chk("R1 wr_n in reset", wr_n, 1'b1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 ale", ale, 1'b0);
    chk("R1 rd_n", rd_n, 1'b1);
    chk("R1 wr_n", wr_n, 1'b1);
    chk("R1 ad_oe", ad_oe, 1'b0);
    chk("R1 ad_out", ad_out, 8'h00);
    chk("R1 addr_hi", addr_hi, 8'h00);
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);

    for (int i = 0; i < 18; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = (i < 16) ? (16'h0001 << i) : ((i == 16) ? 16'h0000 : 16'hFFFF);
      d = 8'h3C ^ 8'(i * 37);
      for (int w = 0; w < 2; w++) begin
        access(w[0], a, d ^ {8{w[0]}}, (i % 3) == 1);
        chk("R8 rdata after access", rdata, exp_rdata);
      end
    end

    // write right after a read must leave the captured byte alone
    access(1'b0, 16'hA55A, 8'hC3, 1'b0);
    access(1'b1, 16'h5AA5, 8'h0F, 1'b1);
    chk("R8 rdata kept across write", rdata, 8'hC3);
    repeat (3) @(negedge clk);
    chk("R11 idle after jammed access", busy, 1'b0);
    finish_run();
  end

endmodule